// File: doc/BRIEF.md
# Out-of-Band Time/Date and Temperature Responder

This block answers short out-of-band requests from a peripheral device with one of two stored values: a one-byte die temperature, or a real-time-clock snapshot of seven bytes. The temperature byte is captured whenever the sensor pulses its update strobe, which happens roughly once per millisecond. The clock bytes are captured as one group on a periodic capture tick. Both values stay in registers until the next capture. They are cleared only by reset, so they can still be read while the host sleeps.

A request is a byte stream. The first byte is the destination address, the second is the requester's address, and any further bytes up to the end marker are ignored. The responder that is chosen depends only on the destination byte. When a complete request names the temperature destination or the clock destination, the block emits a posted response stream. The response starts with a three-byte header: the requester's address, the responding destination address, and the payload byte count. The payload follows. All clock bytes in a response come from one capture, so the device never sees a time torn across a rollover.

Top module: `oob_stat_responder`

## Requirements
- R1: After reset `rsp_valid` is low and both stored values are zero, so a temperature request made before any capture returns a payload byte of 0.
- R2: A request whose first byte equals `DEST_TEMP` (default 0x1A) and that ends on its second byte or later produces four bytes: requester address, `DEST_TEMP`, 0x01, stored temperature. The first of these bytes is valid in the cycle after the clock edge that accepts the final request byte.
- R3: A request addressed to `DEST_RTC` (default 0x1B) produces ten bytes: requester address, `DEST_RTC`, 0x07, then the clock bytes in the order seconds, minutes, hours, day of week, day of month, month, year. Clock byte i is taken from `rtc_value[8i+7:8i]`.
- R4: Response bytes appear on consecutive cycles with no gap. `rsp_last` is high only with the final byte, and `rsp_valid` falls in the cycle after it.
- R5: A request to any other destination, or a request that ends on its first byte, produces no response.
- R6: A request whose final byte arrives while a response is being sent is discarded and produces no response.
- R7: A capture strobe or tick that arrives during a response does not change any byte of that response.
- R8: A capture is published at the first clock edge after it at which no response is in progress. When several captures arrive before publication, the newest one wins. A request completing at that same edge, or later, receives the new value. A request completing on the capture edge itself receives the previous value.
- R9: Stored values persist without further captures, so repeated requests return identical payloads.
- R10: Request bytes after the second do not affect the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request byte present |
| req_data | input | 8 | Request byte |
| req_last | input | 1 | Final byte of the request |
| temp_value | input | 8 | Temperature from the sensor |
| temp_update | input | 1 | Temperature capture strobe |
| rtc_value | input | 8*RTC_BYTES | Clock bytes, byte 0 = seconds |
| rtc_tick | input | 1 | Clock capture tick |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |

## Verification
The header byte of a response is due one cycle after the edge that accepts the final request byte. Each following byte is due one cycle later, and a capture takes effect at the first idle edge after it. A behavioural model in the bench reproduces these delays with a byte queue and pending flags. It samples inputs at each rising edge and compares all three response outputs at every falling edge. The cases covered are a capture landing exactly at a request edge, captures landing mid-response, and requests arriving mid-response.

// File: rtl/oob_resp_pkg.sv
package oob_resp_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_TEMP = 2'd1,
    KIND_RTC  = 2'd2
  } oob_kind_e;

  localparam int unsigned HDR_BYTES = 3;

  // payload byte count carried in the header
  function automatic int unsigned payload_bytes(oob_kind_e k, int unsigned rtc_n);
    if (k == KIND_RTC)  return rtc_n;
    if (k == KIND_TEMP) return 1;
    return 0;
  endfunction

  // total bytes in a response frame
  function automatic int unsigned frame_bytes(oob_kind_e k, int unsigned rtc_n);
    return HDR_BYTES + payload_bytes(k, rtc_n);
  endfunction
endpackage

// File: rtl/oob_req_parser.sv
module oob_req_parser
  import oob_resp_pkg::*;
#(
  parameter logic [7:0] DEST_TEMP = 8'h1A,
  parameter logic [7:0] DEST_RTC  = 8'h1B
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic [7:0] req_data,
  input  logic      req_last,
  output logic      req_done,
  output oob_kind_e req_kind,
  output logic [7:0] req_src
);
  logic [1:0] pos_q;
  logic [7:0] dest_q;
  logic [7:0] src_q;
  logic       ends_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      dest_q <= '0;
      src_q  <= '0;
    end else if (req_valid) begin
      if (pos_q == 2'd0) dest_q <= req_data;
      if (pos_q == 2'd1) src_q  <= req_data;
      if (req_last)            pos_q <= '0;
      else if (pos_q != 2'd2)  pos_q <= pos_q + 2'd1;
    end
  end

  always_comb begin
    req_src  = (pos_q == 2'd1) ? req_data : src_q;
    ends_now = req_valid && req_last && (pos_q != 2'd0);
    if (dest_q == DEST_TEMP)     req_kind = KIND_TEMP;
    else if (dest_q == DEST_RTC) req_kind = KIND_RTC;
    else                         req_kind = KIND_NONE;
    req_done = ends_now && (req_kind != KIND_NONE);
  end
endmodule

// File: rtl/oob_hold_reg.sv
module oob_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_tick,
  input  logic [W-1:0] cap_data,
  input  logic         freeze,
  output logic [W-1:0] pub_data
);
  logic [W-1:0] stage_q;
  logic         pend_q;
  logic         publish;

  assign publish = pend_q && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      pend_q   <= 1'b0;
      pub_data <= '0;
    end else begin
      if (publish) pub_data <= stage_q;
      if (cap_tick) begin
        stage_q <= cap_data;
        pend_q  <= 1'b1;
      end else if (publish) begin
        pend_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/oob_rsp_seq.sv
module oob_rsp_seq
  import oob_resp_pkg::*;
#(
  parameter int unsigned RTC_BYTES = 7,
  parameter logic [7:0]  DEST_TEMP = 8'h1A,
  parameter logic [7:0]  DEST_RTC  = 8'h1B,
  localparam int unsigned RTC_W    = 8 * RTC_BYTES,
  localparam int unsigned MAX_LEN  = HDR_BYTES + RTC_BYTES,
  localparam int unsigned IDX_W    = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  oob_kind_e        start_kind,
  input  logic [7:0]       start_src,
  input  logic [7:0]       temp_pub,
  input  logic [RTC_W-1:0] rtc_pub,
  output logic             busy,
  output logic             launch,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_last
);
  oob_kind_e        kind_q;
  logic [7:0]       src_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       rtc_byte;

  assign launch   = start && !busy;
  assign last_idx = IDX_W'(frame_bytes(kind_q, RTC_BYTES) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      kind_q <= KIND_NONE;
      src_q  <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      kind_q <= start_kind;
      src_q  <= start_src;
    end else if (busy) begin
      if (idx_q == last_idx) busy <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    rtc_byte = '0;
    for (int i = 0; i < RTC_BYTES; i++) begin
      if (idx_q == IDX_W'(i + HDR_BYTES)) rtc_byte = rtc_pub[8*i +: 8];
    end
  end

  always_comb begin
    rsp_valid = busy;
    rsp_last  = busy && (idx_q == last_idx);
    case (idx_q)
      IDX_W'(0): rsp_data = src_q;
      IDX_W'(1): rsp_data = (kind_q == KIND_RTC) ? DEST_RTC : DEST_TEMP;
      IDX_W'(2): rsp_data = 8'(payload_bytes(kind_q, RTC_BYTES));
      default:   rsp_data = (kind_q == KIND_RTC) ? rtc_byte : temp_pub;
    endcase
    if (!busy) rsp_data = '0;
  end
endmodule

// File: rtl/oob_stat_responder.sv
module oob_stat_responder
  import oob_resp_pkg::*;
#(
  parameter int unsigned RTC_BYTES = 7,
  parameter logic [7:0]  DEST_TEMP = 8'h1A,
  parameter logic [7:0]  DEST_RTC  = 8'h1B,
  localparam int unsigned RTC_W    = 8 * RTC_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_data,
  input  logic             req_last,
  input  logic [7:0]       temp_value,
  input  logic             temp_update,
  input  logic [RTC_W-1:0] rtc_value,
  input  logic             rtc_tick,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_last
);
  // named internal events for the checker
  logic             ev_done;
  logic             ev_launch;
  logic             ev_busy;
  oob_kind_e        ev_kind;
  logic [7:0]       ev_src;
  logic [7:0]       temp_snap;
  logic [RTC_W-1:0] rtc_snap;

  oob_req_parser #(.DEST_TEMP(DEST_TEMP), .DEST_RTC(DEST_RTC)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
    .req_done(ev_done), .req_kind(ev_kind), .req_src(ev_src)
  );

  oob_hold_reg #(.W(8)) u_temp_hold (
    .clk(clk), .rst_n(rst_n),
    .cap_tick(temp_update), .cap_data(temp_value),
    .freeze(ev_busy), .pub_data(temp_snap)
  );

  oob_hold_reg #(.W(RTC_W)) u_rtc_hold (
    .clk(clk), .rst_n(rst_n),
    .cap_tick(rtc_tick), .cap_data(rtc_value),
    .freeze(ev_busy), .pub_data(rtc_snap)
  );

  oob_rsp_seq #(
    .RTC_BYTES(RTC_BYTES), .DEST_TEMP(DEST_TEMP), .DEST_RTC(DEST_RTC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(ev_done), .start_kind(ev_kind), .start_src(ev_src),
    .temp_pub(temp_snap), .rtc_pub(rtc_snap),
    .busy(ev_busy), .launch(ev_launch),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );
endmodule

// File: rtl/oob_resp_checker.sv
module oob_resp_checker #(
  parameter int unsigned RTC_BYTES = 7,
  parameter logic [7:0]  DEST_TEMP = 8'h1A,
  parameter logic [7:0]  DEST_RTC  = 8'h1B,
  localparam int unsigned RTC_W    = 8 * RTC_BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_last,
  input logic             rsp_valid,
  input logic [7:0]       rsp_data,
  input logic             rsp_last,
  input logic             ev_busy,
  input logic             ev_launch,
  input logic [7:0]       temp_snap,
  input logic [RTC_W-1:0] rtc_snap
);
  assert_last_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid);

  assert_ends_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);

  assert_start_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_last));

  assert_dest_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |=> (rsp_data == DEST_TEMP || rsp_data == DEST_RTC));

  assert_count_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |=> ##1 (rsp_data == 8'd1 || rsp_data == 8'(RTC_BYTES)));

  assert_snap_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |=> ($stable(rtc_snap) && $stable(temp_snap)));

  assert_drop_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_last && ev_busy) |-> !ev_launch);
endmodule

bind oob_stat_responder oob_resp_checker #(
  .RTC_BYTES(RTC_BYTES), .DEST_TEMP(DEST_TEMP), .DEST_RTC(DEST_RTC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_last(req_last),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
  .ev_busy(ev_busy), .ev_launch(ev_launch),
  .temp_snap(temp_snap), .rtc_snap(rtc_snap)
);

// File: tb/oob_stat_responder_bench.sv
module oob_stat_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 7;
  localparam logic [7:0] DT = 8'h1A;
  localparam logic [7:0] DR = 8'h1B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_data = '0;
  logic req_last = 1'b0;
  logic [7:0] temp_value = '0;
  logic temp_update = 1'b0;
  logic [8*NB-1:0] rtc_value = '0;
  logic rtc_tick = 1'b0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic rsp_last;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";
  bit done_run = 1'b0;
  int cycles = 0;

  oob_stat_responder #(.RTC_BYTES(NB), .DEST_TEMP(DT), .DEST_RTC(DR)) u_oob_stat_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_last(req_last), .temp_value(temp_value), .temp_update(temp_update),
    .rtc_value(rtc_value), .rtc_tick(rtc_tick),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  byte unsigned mq[$];
  int m_pos;
  logic [7:0] m_dest, m_src, src_now;
  logic [7:0] t_stage, t_pub;
  logic [8*NB-1:0] r_stage, r_pub;
  bit t_pend, r_pend, was_busy;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mq.delete();
      m_pos = 0; m_dest = 0; m_src = 0;
      t_stage = 0; t_pub = 0; r_stage = 0; r_pub = 0;
      t_pend = 0; r_pend = 0;
    end else begin
      was_busy = (mq.size() > 0);
      if (was_busy) void'(mq.pop_front());
      if (!was_busy && t_pend) t_pub = t_stage;
      if (!was_busy && r_pend) r_pub = r_stage;
      if (temp_update) begin t_stage = temp_value; t_pend = 1; end
      else if (!was_busy) t_pend = 0;
      if (rtc_tick) begin r_stage = rtc_value; r_pend = 1; end
      else if (!was_busy) r_pend = 0;
      if (req_valid) begin
        src_now = (m_pos == 1) ? req_data : m_src;
        if (req_last && m_pos >= 1 && !was_busy) begin
          if (m_dest == DT) begin
            mq.push_back(src_now); mq.push_back(DT); mq.push_back(8'd1); mq.push_back(t_pub);
          end else if (m_dest == DR) begin
            mq.push_back(src_now); mq.push_back(DR); mq.push_back(8'(NB));
            for (int i = 0; i < NB; i++) mq.push_back(r_pub[8*i +: 8]);
          end
        end
        if (m_pos == 0) m_dest = req_data;
        if (m_pos == 1) m_src = req_data;
        if (req_last) m_pos = 0;
        else if (m_pos < 2) m_pos++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (valid,last,data)", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      logic [9:0] a, e;
      a = {rsp_valid, rsp_last, rsp_data};
      if (mq.size() > 0) e = {1'b1, mq.size() == 1, 8'(mq[0])};
      else               e = {1'b0, 1'b0, rsp_data};
      check(a == e, cur_tag, a, e);
    end
  end

  task automatic send(input byte unsigned b[$]);
    foreach (b[i]) begin
      req_valid = 1'b1; req_data = b[i]; req_last = (i == b.size() - 1);
      @(negedge clk);
    end
    req_valid = 1'b0; req_last = 1'b0; req_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done_run) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      summary();
    end
  end

  initial begin
    idle(3);
    // R1: outputs idle while in reset
    check(rsp_valid == 1'b0, "R1", {rsp_valid, rsp_last, rsp_data}, 10'h0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    check(rsp_valid == 1'b0, "R1", {rsp_valid, rsp_last, rsp_data}, 10'h0);
    cur_tag = "R1"; send('{DT, 8'h21}); idle(6);

    cur_tag = "R2";
    temp_value = 8'h3C; temp_update = 1'b1; @(negedge clk); temp_update = 1'b0;
    idle(2); send('{DT, 8'h42}); idle(6);

    cur_tag = "R3";
    rtc_value = 56'h23_0C_1F_06_17_3B_3B; rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    idle(2); send('{DR, 8'h55}); idle(12);

    cur_tag = "R10"; send('{DR, 8'h56, 8'h99, DT, 8'h07}); idle(12);

    cur_tag = "R5"; send('{8'h77, 8'h10}); idle(4);
    send('{DT}); idle(4); send('{8'h00, 8'h01, 8'h02}); idle(4);

    cur_tag = "R6"; send('{DR, 8'h31}); send('{DT, 8'h32}); send('{DR, 8'h33}); idle(12);

    cur_tag = "R4"; send('{DT, 8'h60}); idle(3); send('{DT, 8'h61}); send('{DR, 8'h62}); idle(12);

    cur_tag = "R7"; send('{DR, 8'h70});
    rtc_value = 56'h24_01_01_00_00_00_00; rtc_tick = 1'b1;
    temp_value = 8'h50; temp_update = 1'b1; @(negedge clk);
    rtc_value = 56'h24_01_01_01_02_03_04; temp_value = 8'h51; @(negedge clk);
    rtc_tick = 1'b0; temp_update = 1'b0; idle(12);

    cur_tag = "R8"; send('{DR, 8'h71}); idle(12);
    send('{DT, 8'h72}); idle(6);
    // capture on the edge that completes a request: old value
    req_valid = 1'b1; req_data = DT; @(negedge clk);
    req_data = 8'h73; req_last = 1'b1; temp_value = 8'h66; temp_update = 1'b1; @(negedge clk);
    req_valid = 1'b0; req_last = 1'b0; temp_update = 1'b0; idle(6);
    // capture one edge before completion: new value
    temp_value = 8'h77; temp_update = 1'b1; req_valid = 1'b1; req_data = DT; @(negedge clk);
    temp_update = 1'b0; req_data = 8'h74; req_last = 1'b1; @(negedge clk);
    req_valid = 1'b0; req_last = 1'b0; idle(6);

    cur_tag = "R9"; idle(20); send('{DR, 8'h80}); idle(12); send('{DR, 8'h81}); idle(12);
    send('{DT, 8'h82}); idle(6);

    summary();
  end
endmodule